// File: doc/BRIEF.md
# Page Translation Cache with Two-Level Walker

This block turns 32-bit linear addresses into physical addresses for a memory system that is split into 4 KB pages. It keeps a small fully associative cache of recent page translations. A lookup that finds its page there is answered on the next clock edge, and that answer needs no memory traffic at all. A lookup that misses starts a hardware walk. The walk first reads a directory entry, then a table entry, through a single memory read port. If both entries are present, the new translation is written into the cache.

The client offers a request with a valid/ready handshake. The response is a one-cycle pulse that carries the physical address or a fault flag. Only one walk can be in flight, so the ready signal stays low while a walk runs. The base frame of the directory comes from a static input. A flush input wipes every cached translation within a single cycle. When a flush lands in the same cycle as a lookup or as the end of a walk, the flush takes priority over both.

Top module: `tlb_xlate`

## Requirements
- R1: Right after reset, req_ready is 1, rsp_valid is 0 and mem_req is 0. The cache holds no valid entry, so the first lookup of any page starts a walk.
- R2: When an accepted request hits, rsp_valid is 1 in the following cycle with rsp_fault 0. No memory read is issued for that request.
- R3: Bits 11:0 of rsp_paddr always equal bits 11:0 of the request address. Bits 31:12 hold the cached or walked frame number.
- R4: On a miss the walker makes exactly two reads. The first read is at {dir_frame, va[31:22], 2'b00}. The second is at {directory entry bits 31:12, va[21:12], 2'b00}. mem_addr does not change while a read waits for mem_rvalid.
- R5: From the cycle after a miss is accepted until the response, req_ready is 0. It is 1 again in the cycle in which rsp_valid is 1.
- R6: If bit 0 (present) of the directory entry is clear, the walk ends after that one read and the response has rsp_fault set. Nothing is installed, so the same page walks again next time.
- R7: If bit 0 of the table entry is clear, the response has rsp_fault set after two reads. Nothing is installed.
- R8: The cache holds 32 distinct pages at once. After 32 different pages are loaded, all 32 of them hit.
- R9: A refill replaces the least recently used entry, and every hit makes its entry the most recently used.
- R10: One cycle of flush invalidates all entries. The next lookup of any page walks again.
- R11: If flush is high in the same cycle that a request is accepted, that request is handled as a miss. If flush is high in the same cycle that a walk's final read returns, the response is still given but no entry is installed.
- R12: A translation that succeeds, whether by hit or by walk, returns rsp_fault 0 and the frame from the table entry bits 31:12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_vaddr | input | 32 | Linear address to translate |
| req_ready | output | 1 | Block can accept a request (no walk in progress) |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_paddr | output | 32 | Physical address (0 when faulted) |
| rsp_fault | output | 1 | Walk met an entry with present bit clear |
| dir_frame | input | 20 | Frame number of the page directory |
| flush | input | 1 | Invalidate all cached translations |
| mem_req | output | 1 | Walk read request, held until data returns |
| mem_addr | output | 32 | Walk read byte address |
| mem_rvalid | input | 1 | Read data valid, accepted while mem_req is high |
| mem_rdata | input | 32 | Read data (directory or table entry) |

## Verification
Flush is the function that can fall in the same cycle as the others. It can coincide with a lookup acceptance, and it can coincide with the cycle in which the walker's last read returns and a refill would be written. The bench raises flush together with req_valid for a page that is already cached. It also raises flush exactly when the memory model presents the second read of a walk. In each case it judges the result by counting the memory reads of the next lookup of the same page: two reads mean nothing survived, and zero reads mean the entry was kept.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    // Width of one directory or table entry in memory.
    localparam int unsigned ENTRY_W = 32;

    typedef enum logic [1:0] {
        WK_IDLE,
        WK_DIR,
        WK_TBL
    } walk_st_e;
endpackage

// File: rtl/tlb_lru.sv
module tlb_lru #(
    parameter int unsigned ENTRIES = 32,
    localparam int unsigned IW = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid,
    input  logic               touch_en,
    input  logic [IW-1:0]      touch_idx,
    output logic [IW-1:0]      victim_idx
);
    // Each entry carries an age rank. The ranks always form a permutation of 0..ENTRIES-1,
    // and rank ENTRIES-1 marks the least recently used entry.
    typedef struct packed {
        logic [ENTRIES-1:0][IW-1:0] age;
    } lru_t;

    function automatic lru_t reset_ages();
        lru_t r;
        for (int i = 0; i < ENTRIES; i++) r.age[i] = IW'(i);
        return r;
    endfunction

    lru_t s_d, s_q;
    logic [ENTRIES-1:0] is_old;
    logic               free_found;
    logic [IW-1:0]      ref_age;

    always_comb begin
        // An invalid entry is used before any valid one is evicted; the lowest index goes first.
        victim_idx = '0;
        free_found = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!free_found && !valid[i]) begin
                victim_idx = IW'(i);
                free_found = 1'b1;
            end
        end
        for (int i = 0; i < ENTRIES; i++) begin
            is_old[i] = (s_q.age[i] == IW'(ENTRIES - 1));
        end
        if (!free_found) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (is_old[i]) victim_idx = IW'(i);
            end
        end

        s_d     = s_q;
        ref_age = s_q.age[touch_idx];
        if (touch_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IW'(i) == touch_idx) begin
                    s_d.age[i] = '0;
                end else if (s_q.age[i] < ref_age) begin
                    s_d.age[i] = s_q.age[i] + IW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= reset_ages();
        else        s_q <= s_d;
    end

    // R9
    lru_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(is_old) == 1);
endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
    parameter int unsigned ENTRIES = 32,
    parameter int unsigned VPN_W   = 20,
    parameter int unsigned PFN_W   = 20,
    localparam int unsigned IW = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             look_en,
    input  logic [VPN_W-1:0] look_vpn,
    input  logic             flush,
    input  logic             fill_en,
    input  logic [IW-1:0]    fill_idx,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    output logic             hit,
    output logic [IW-1:0]    hit_idx,
    output logic [PFN_W-1:0] hit_pfn,
    output logic [ENTRIES-1:0] valid_o
);
    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][VPN_W-1:0]  vpn;
        logic [ENTRIES-1:0][PFN_W-1:0]  pfn;
    } store_t;

    store_t s_d, s_q;
    logic [ENTRIES-1:0] match;

    always_comb begin
        hit_idx = '0;
        hit_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            match[i] = s_q.valid[i] && (s_q.vpn[i] == look_vpn);
            if (match[i]) begin
                hit_idx = hit_idx | IW'(i);
                hit_pfn = hit_pfn | s_q.pfn[i];
            end
        end
        // A flush in the same cycle overrides the lookup.
        hit = look_en && (|match) && !flush;

        s_d = s_q;
        if (flush) begin
            s_d.valid = '0;
        end else if (fill_en) begin
            s_d.valid[fill_idx] = 1'b1;
            s_d.vpn[fill_idx]   = fill_vpn;
            s_d.pfn[fill_idx]   = fill_pfn;
        end
    end

    assign valid_o = s_q.valid;

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R10
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (s_q.valid == '0));

    // R8
    uniq_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/tlb_walker.sv
module tlb_walker
    import tlb_pkg::*;
#(
    parameter int unsigned OFF_W = 12,
    parameter int unsigned IDX_W = 10,
    localparam int unsigned VA_W  = OFF_W + 2 * IDX_W,
    localparam int unsigned PFN_W = ENTRY_W - OFF_W,
    localparam int unsigned VPN_W = 2 * IDX_W,
    localparam int unsigned PA_W  = PFN_W + OFF_W,
    localparam int unsigned ENT_SH = OFF_W - IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [VA_W-1:0]    start_va,
    input  logic [PFN_W-1:0]   dir_frame,
    input  logic               mem_rvalid,
    input  logic [ENTRY_W-1:0] mem_rdata,
    output logic               busy,
    output logic               mem_req,
    output logic [PA_W-1:0]    mem_addr,
    output logic               done,
    output logic               done_fault,
    output logic [PFN_W-1:0]   done_pfn,
    output logic [VPN_W-1:0]   walk_vpn,
    output logic [OFF_W-1:0]   walk_off
);
    typedef struct packed {
        walk_st_e          state;
        logic [VA_W-1:0]   va;
        logic [PFN_W-1:0]  tbl_pfn;
    } walk_t;

    walk_t s_d, s_q;
    logic  entry_present;
    logic  unused_rdata_flags;

    assign entry_present      = mem_rdata[0];
    assign unused_rdata_flags = ^mem_rdata[OFF_W-1:1];

    always_comb begin
        s_d        = s_q;
        mem_req    = 1'b0;
        mem_addr   = '0;
        done       = 1'b0;
        done_fault = 1'b0;
        done_pfn   = mem_rdata[ENTRY_W-1 -: PFN_W];
        case (s_q.state)
            WK_IDLE: begin
                if (start) begin
                    s_d.va    = start_va;
                    s_d.state = WK_DIR;
                end
            end
            WK_DIR: begin
                mem_req  = 1'b1;
                mem_addr = {dir_frame, s_q.va[VA_W-1 -: IDX_W], {ENT_SH{1'b0}}};
                if (mem_rvalid) begin
                    if (entry_present) begin
                        s_d.tbl_pfn = mem_rdata[ENTRY_W-1 -: PFN_W];
                        s_d.state   = WK_TBL;
                    end else begin
                        done       = 1'b1;
                        done_fault = 1'b1;
                        s_d.state  = WK_IDLE;
                    end
                end
            end
            WK_TBL: begin
                mem_req  = 1'b1;
                mem_addr = {s_q.tbl_pfn, s_q.va[OFF_W+IDX_W-1 -: IDX_W], {ENT_SH{1'b0}}};
                if (mem_rvalid) begin
                    done       = 1'b1;
                    done_fault = !entry_present;
                    s_d.state  = WK_IDLE;
                end
            end
            default: s_d.state = WK_IDLE;
        endcase
    end

    assign busy     = (s_q.state != WK_IDLE);
    assign walk_vpn = s_q.va[VA_W-1 -: VPN_W];
    assign walk_off = s_q.va[OFF_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{state: WK_IDLE, va: '0, tbl_pfn: '0};
        else        s_q <= s_d;
    end

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R6
    dir_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == WK_DIR && mem_rvalid && !entry_present) |=> !busy);
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 32,
    parameter int unsigned OFF_W   = 12,
    parameter int unsigned IDX_W   = 10,
    localparam int unsigned VA_W  = OFF_W + 2 * IDX_W,
    localparam int unsigned PFN_W = ENTRY_W - OFF_W,
    localparam int unsigned VPN_W = 2 * IDX_W,
    localparam int unsigned PA_W  = PFN_W + OFF_W,
    localparam int unsigned IW    = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    output logic               req_ready,
    output logic               rsp_valid,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic               rsp_fault,
    input  logic [PFN_W-1:0]   dir_frame,
    input  logic               flush,
    output logic               mem_req,
    output logic [PA_W-1:0]    mem_addr,
    input  logic               mem_rvalid,
    input  logic [ENTRY_W-1:0] mem_rdata
);
    typedef struct packed {
        logic            valid;
        logic [PA_W-1:0] paddr;
        logic            fault;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic               busy, accept, hit, start_walk, install, touch_en;
    logic [IW-1:0]      hit_idx, victim_idx, touch_idx;
    logic [PFN_W-1:0]   hit_pfn, walk_pfn;
    logic [VPN_W-1:0]   walk_vpn;
    logic [OFF_W-1:0]   walk_off;
    logic               walk_done, walk_fault;
    logic [ENTRIES-1:0] valid_vec;

    assign req_ready  = !busy;
    assign accept     = req_valid && req_ready;
    assign start_walk = accept && !hit;
    // A flush in the cycle a walk ends cancels the refill.
    assign install    = walk_done && !walk_fault && !flush;
    assign touch_en   = hit || install;
    assign touch_idx  = hit ? hit_idx : victim_idx;

    tlb_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .look_en  (accept),
        .look_vpn (req_vaddr[VA_W-1 -: VPN_W]),
        .flush    (flush),
        .fill_en  (install),
        .fill_idx (victim_idx),
        .fill_vpn (walk_vpn),
        .fill_pfn (walk_pfn),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .hit_pfn  (hit_pfn),
        .valid_o  (valid_vec)
    );

    tlb_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (valid_vec),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .victim_idx (victim_idx)
    );

    tlb_walker #(.OFF_W(OFF_W), .IDX_W(IDX_W)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_walk),
        .start_va   (req_vaddr),
        .dir_frame  (dir_frame),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .done       (walk_done),
        .done_fault (walk_fault),
        .done_pfn   (walk_pfn),
        .walk_vpn   (walk_vpn),
        .walk_off   (walk_off)
    );

    always_comb begin
        rsp_d = '0;
        if (hit) begin
            rsp_d.valid = 1'b1;
            rsp_d.paddr = {hit_pfn, req_vaddr[OFF_W-1:0]};
        end else if (walk_done) begin
            rsp_d.valid = 1'b1;
            rsp_d.fault = walk_fault;
            rsp_d.paddr = walk_fault ? '0 : {walk_pfn, walk_off};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_paddr = rsp_q.paddr;
    assign rsp_fault = rsp_q.fault;

    // R5
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    // R2
    hit_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit) |=> (rsp_valid && !rsp_fault && !mem_req));

    // R7
    fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_valid && rsp_paddr == '0));
endmodule

// File: tb/sim_tlb_xlate.sv
module sim_tlb_xlate;
    localparam int CLK_PERIOD = 10;
    localparam logic [19:0] PD_FRAME = 20'h00100;

    logic        clk, rst_n;
    logic        req_valid, req_ready, rsp_valid, rsp_fault, flush;
    logic [31:0] req_vaddr, rsp_paddr, mem_addr, mem_rdata;
    logic        mem_req, mem_rvalid;
    logic [19:0] dir_frame;

    int n_chk = 0, n_fail = 0, mem_reads = 0, lat_cnt = 0;
    logic [31:0] rd_log [2];

    tlb_xlate u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .dir_frame(dir_frame), .flush(flush),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory image: directory entry d points at frame 0x200+d, present unless d is all ones.
    // Table entry t in that frame maps to {low byte of 0x200+d, t, 2'b01}, present unless t is all ones.
    function automatic logic [31:0] mem_f(input logic [31:0] a);
        logic [11:0] s;
        if (a[31:12] == PD_FRAME) begin
            s = 12'h200 + {2'b00, a[11:2]};
            return {8'h00, s, 11'b0, (a[11:2] != 10'h3FF)};
        end
        return {a[19:12], a[11:2], 2'b01, 11'b0, (a[11:2] != 10'h3FF)};
    endfunction

    function automatic logic [31:0] ref_pa(input logic [31:0] va);
        logic [11:0] s;
        s = 12'h200 + {2'b00, va[31:22]};
        return {s[7:0], va[21:12], 2'b01, va[11:0]};
    endfunction

    // Read responder: data two cycles after the request is seen.
    initial begin
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        forever begin
            @(negedge clk);
            if (mem_rvalid) begin
                mem_rvalid = 1'b0;
                lat_cnt    = 0;
            end else if (mem_req) begin
                lat_cnt++;
                if (lat_cnt >= 2) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = mem_f(mem_addr);
                    rd_log[0]  = rd_log[1];
                    rd_log[1]  = mem_addr;
                    mem_reads++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xlate(input logic [31:0] va, input bit fl_req, input bit fl_fill,
                         output logic [31:0] pa, output bit flt, output int nrd, output bit rdy_ok);
        int r0;
        int w;
        r0 = mem_reads;
        @(negedge clk); #1;
        req_valid = 1'b1; req_vaddr = va; flush = fl_req;
        @(negedge clk); #1;
        req_valid = 1'b0; flush = 1'b0;
        rdy_ok = 1'b1;
        w = 0;
        while (!rsp_valid && w < 200) begin
            if (req_ready) rdy_ok = 1'b0;
            @(negedge clk); #1;
            flush = fl_fill && mem_rvalid && ((mem_reads - r0) == 2);
            w++;
        end
        flush = 1'b0;
        if (w >= 200) chk(1'b0, "timeout", 32'(w), 32'd0);
        pa  = rsp_paddr;
        flt = rsp_fault;
        nrd = mem_reads - r0;
        if (!req_ready) rdy_ok = 1'b0;
    endtask

    task automatic flush_pulse();
        @(negedge clk); #1; flush = 1'b1;
        @(negedge clk); #1; flush = 1'b0;
    endtask

    // {address, expected hit}
    localparam logic [32:0] VEC [8] = '{
        {32'h0040_5123, 1'b0},
        {32'h0040_5FFF, 1'b1},
        {32'h0040_6000, 1'b0},
        {32'h0080_5004, 1'b0},
        {32'h0040_5000, 1'b1},
        {32'h0080_5ABC, 1'b1},
        {32'hC030_2010, 1'b0},
        {32'h0040_6789, 1'b1}
    };

    initial begin
        logic [31:0] pa, va;
        bit flt, rdy;
        int nrd, bad;
        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; flush = 1'b0; dir_frame = PD_FRAME;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        chk(req_ready && !rsp_valid && !mem_req, "R1 reset outputs",
            {29'b0, req_ready, rsp_valid, mem_req}, 32'h4);

        for (int i = 0; i < 8; i++) begin
            va = VEC[i][32:1];
            xlate(va, 1'b0, 1'b0, pa, flt, nrd, rdy);
            chk(pa == ref_pa(va), "R3 R12 paddr", pa, ref_pa(va));
            chk(!flt, "R12 no fault", 32'(flt), 32'd0);
            if (VEC[i][0]) begin
                chk(nrd == 0, "R2 hit reads", 32'(nrd), 32'd0);
            end else begin
                chk(nrd == 2, "R1 R4 miss reads", 32'(nrd), 32'd2);
                chk(rd_log[0] == {PD_FRAME, va[31:22], 2'b00}, "R4 dir addr",
                    rd_log[0], {PD_FRAME, va[31:22], 2'b00});
                chk(rd_log[1] == {8'h00, 12'h200 + {2'b00, va[31:22]}, va[21:12], 2'b00},
                    "R4 table addr", rd_log[1],
                    {8'h00, 12'h200 + {2'b00, va[31:22]}, va[21:12], 2'b00});
                chk(rdy, "R5 ready during walk", 32'(rdy), 32'd1);
            end
        end

        // R6 directory entry not present
        for (int k = 0; k < 2; k++) begin
            xlate(32'hFFC0_0123, 1'b0, 1'b0, pa, flt, nrd, rdy);
            chk(flt && nrd == 1, "R6 dir fault", {pa[30:0], flt}, 32'd1);
        end
        // R7 table entry not present
        for (int k = 0; k < 2; k++) begin
            xlate(32'h017F_F000, 1'b0, 1'b0, pa, flt, nrd, rdy);
            chk(flt && nrd == 2, "R7 table fault", 32'(nrd), 32'd2);
        end

        // R10 flush alone
        flush_pulse();
        xlate(32'h0040_5123, 1'b0, 1'b0, pa, flt, nrd, rdy);
        chk(nrd == 2, "R10 walk after flush", 32'(nrd), 32'd2);

        // R11 flush with request acceptance: miss, then the refill survives
        xlate(32'h0040_5123, 1'b1, 1'b0, pa, flt, nrd, rdy);
        chk(nrd == 2 && pa == ref_pa(32'h0040_5123), "R11 flush at request", 32'(nrd), 32'd2);
        xlate(32'h0040_5123, 1'b0, 1'b0, pa, flt, nrd, rdy);
        chk(nrd == 0, "R11 refill kept", 32'(nrd), 32'd0);

        // R11 flush with final walk read: answer given, nothing installed
        xlate(32'h0C00_1234, 1'b0, 1'b1, pa, flt, nrd, rdy);
        chk(pa == ref_pa(32'h0C00_1234) && !flt, "R11 flush at refill answer", pa, ref_pa(32'h0C00_1234));
        xlate(32'h0C00_1234, 1'b0, 1'b0, pa, flt, nrd, rdy);
        chk(nrd == 2, "R11 refill dropped", 32'(nrd), 32'd2);

        // R8 capacity and R9 replacement order
        flush_pulse();
        for (int k = 0; k < 32; k++) xlate({10'd7, 10'(k), 12'h0}, 1'b0, 1'b0, pa, flt, nrd, rdy);
        bad = 0;
        for (int k = 0; k < 32; k++) begin
            xlate({10'd7, 10'(k), 12'h0}, 1'b0, 1'b0, pa, flt, nrd, rdy);
            if (nrd != 0) bad++;
        end
        chk(bad == 0, "R8 32 pages resident", 32'(bad), 32'd0);
        xlate({10'd7, 10'd0, 12'h0}, 1'b0, 1'b0, pa, flt, nrd, rdy);
        xlate({10'd7, 10'd32, 12'h0}, 1'b0, 1'b0, pa, flt, nrd, rdy);
        chk(nrd == 2, "R9 new page walks", 32'(nrd), 32'd2);
        xlate({10'd7, 10'd0, 12'h0}, 1'b0, 1'b0, pa, flt, nrd, rdy);
        chk(nrd == 0, "R9 touched page kept", 32'(nrd), 32'd0);
        bad = 0;
        for (int k = 2; k <= 32; k++) begin
            xlate({10'd7, 10'(k), 12'h0}, 1'b0, 1'b0, pa, flt, nrd, rdy);
            if (nrd != 0) bad++;
        end
        chk(bad == 0, "R9 others kept", 32'(bad), 32'd0);
        xlate({10'd7, 10'd1, 12'h0}, 1'b0, 1'b0, pa, flt, nrd, rdy);
        chk(nrd == 2, "R9 LRU page evicted", 32'(nrd), 32'd2);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule